// File: doc/BRIEF.md
# Three-Input Programmable Logic Cell

The cell picks three one-bit operands, one per input slot. Each slot chooses independently among a constant zero, the cell's own fed-back output, an event line and a timer waveform line. The three operands form a 3-bit index into an 8-bit truth table, and the addressed bit is the cell's logic result. That result either leaves the cell directly, with no register on the path, or passes through a short synchronizer chain first.

The synchronizer chain advances on the system clock, or only on the rising edges of input slot 2. With the cell's own output wired back into one slot and the chain stepped by slot 2, a single cell becomes a small state machine. A typical use is dividing an event stream by four. The result also feeds an output pin, and the pin is driven only while the output enable is set.

Top module: `lut3_cell`

## Requirements
- R1: While the cell is disabled (en_i = 0), or while rst_ni is low with the synchronizer selected, out_o and pin_o are 0.
- R2: Each slot select is decoded on its own: 0 gives constant zero, 1 gives the feedback bit, 2 gives evt_i[k] and 3 gives tmr_i[k], where k is the slot number.
- R3: The result is truth_i[{slot2, slot1, slot0}], so truth_i bit n answers index n. An all-zero table gives 0 and an all-one table gives 1.
- R4: With filt_sync_i = 0, out_o follows the table lookup in the same cycle, with no clock edge in between.
- R5: With filt_sync_i = 1 and fclk_in2_i = 0, a change of the lookup result shows on out_o after the second rising clock edge, and not after the first.
- R6: With filt_sync_i = 1 and fclk_in2_i = 1, the chain moves only on a clock edge where slot 2 is 1 and was 0 at the previous edge. While slot 2 stays high, out_o holds, whatever the other slots do.
- R7: The feedback bit is the chain output when filt_sync_i = 1. When filt_sync_i = 0 it is the lookup result delayed by one clock, so a table that inverts feedback makes out_o toggle on every clock.
- R8: Slot 0 on feedback, slot 1 on a timer held at 0, slot 2 on an event line, the chain stepped by slot 2, and truth_i = 8'h10 together divide the event rate by four: out_o is 1 after event pulses 2 and 3 of every group of four.
- R9: pin_o equals out_o when oe_i = 1 and is 0 when oe_i = 0.
- R10: One clock with en_i = 0 clears the chain. After re-enabling with a constant-one result on the system clock, out_o is still 0 after the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Cell enable |
| in0_sel_i | input | 2 | Slot 0 source: 0 zero, 1 feedback, 2 event, 3 timer |
| in1_sel_i | input | 2 | Slot 1 source, same encoding |
| in2_sel_i | input | 2 | Slot 2 source, same encoding |
| evt_i | input | 3 | Event line per slot, bit k for slot k |
| tmr_i | input | 3 | Timer waveform per slot, bit k for slot k |
| truth_i | input | 8 | Truth table, bit n for index n |
| filt_sync_i | input | 1 | 1 = synchronizer chain on the output, 0 = direct |
| fclk_in2_i | input | 1 | 1 = chain stepped by slot 2 rising edges, 0 = every clock |
| oe_i | input | 1 | Pin output enable |
| out_o | output | 1 | Cell result, also the internal feedback source |
| pin_o | output | 1 | Gated pin drive |

## Verification
A table of vectors drives the direct path with every slot on events, every slot on timers, every slot on constant zero, and mixed sources. These vectors separate the index bit order and the slot-to-line mapping, and they catch any mix-up between the event and timer lines. The vectors also include tables in which only the addressed bit is set or cleared, and a table whose neighbouring bit would give a different answer, so an off-by-one index shows. Directed runs then check the two-edge latency of the system-clock chain, and that the chain holds while slot 2 stays high. They also check the toggling feedback loop of the direct path, the clearing on disable, and the divide-by-four pattern over eight event pulses.

// File: rtl/lut3_pkg.sv
package lut3_pkg;
  localparam int unsigned N_IN = 3;
  localparam int unsigned TT_W = 1 << N_IN;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_FB   = 2'd1,
    SRC_EVT  = 2'd2,
    SRC_TMR  = 2'd3
  } src_sel_e;
endpackage

// File: rtl/lut3_in_mux.sv
module lut3_in_mux
  import lut3_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       fb_i,
  input  logic       evt_i,
  input  logic       tmr_i,
  output logic       bit_o
);
  src_sel_e sel;
  assign sel = src_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      SRC_FB:  bit_o = fb_i;
      SRC_EVT: bit_o = evt_i;
      SRC_TMR: bit_o = tmr_i;
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lut3_table.sv
module lut3_table #(
  parameter int unsigned N_IN = 3,
  localparam int unsigned TT_W = 1 << N_IN
) (
  input  logic [N_IN-1:0] idx_i,
  input  logic [TT_W-1:0] truth_i,
  output logic            bit_o
);
  assign bit_o = truth_i[idx_i];
endmodule

// File: rtl/lut3_sync_filt.sv
module lut3_sync_filt #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sync_i,
  input  logic in2_clk_i,
  input  logic in2_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;
  logic              in2_q;
  logic              adv;

  // slot 2 acts as a clock enable on its rising edge, sampled by clk_i
  assign adv = in2_clk_i ? (in2_i & ~in2_q) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
      in2_q <= 1'b0;
    end else begin
      in2_q <= in2_i;
      if (!en_i)
        stg_q <= '0;
      else if (sync_i && adv)
        stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stg_q[STAGES-1];

  a_r10_clear_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (stg_q == '0));

  a_r6_hold_without_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sync_i && !adv) |=> $stable(stg_q));

  a_r5_capture_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sync_i && adv) |=> (stg_q[0] == $past(d_i)));
endmodule

// File: rtl/lut3_cell.sv
module lut3_cell
  import lut3_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [1:0]      in0_sel_i,
  input  logic [1:0]      in1_sel_i,
  input  logic [1:0]      in2_sel_i,
  input  logic [N_IN-1:0] evt_i,
  input  logic [N_IN-1:0] tmr_i,
  input  logic [TT_W-1:0] truth_i,
  input  logic            filt_sync_i,
  input  logic            fclk_in2_i,
  input  logic            oe_i,
  output logic            out_o,
  output logic            pin_o
);
  logic [N_IN*2-1:0] sel_all;
  logic [N_IN-1:0]   in_bit;
  logic              lut_bit;
  logic              filt_q;
  logic              fb_q;
  logic              fb;

  assign sel_all = {in2_sel_i, in1_sel_i, in0_sel_i};

  for (genvar k = 0; k < N_IN; k++) begin : g_slot
    lut3_in_mux u_mux (
      .sel_i (sel_all[2*k +: 2]),
      .fb_i  (fb),
      .evt_i (evt_i[k]),
      .tmr_i (tmr_i[k]),
      .bit_o (in_bit[k])
    );
  end

  lut3_table #(.N_IN(N_IN)) u_table (
    .idx_i   (in_bit),
    .truth_i (truth_i),
    .bit_o   (lut_bit)
  );

  lut3_sync_filt #(.STAGES(SYNC_STAGES)) u_filt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .sync_i    (filt_sync_i),
    .in2_clk_i (fclk_in2_i),
    .in2_i     (in_bit[N_IN-1]),
    .d_i       (lut_bit),
    .q_o       (filt_q)
  );

  // breaks the combinational loop when the chain is bypassed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fb_q <= 1'b0;
    else         fb_q <= en_i & lut_bit;
  end

  assign fb    = filt_sync_i ? filt_q : fb_q;
  assign out_o = en_i & (filt_sync_i ? filt_q : lut_bit);
  assign pin_o = oe_i & out_o;

  a_r3_zero_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !filt_sync_i && truth_i == '0) |-> !out_o);

  a_r3_ones_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !filt_sync_i && truth_i == '1) |-> out_o);

  a_r7_bypass_feedback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !filt_sync_i) |=> (fb_q == $past(out_o)));
endmodule

// File: tb/lut3_cell_bench.sv
`timescale 1ns/1ps
module lut3_cell_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] s0 = 2'd0, s1 = 2'd0, s2 = 2'd0;
  logic [2:0] evt = '0, tmr = '0;
  logic [7:0] tt = '0;
  logic       fsync = 1'b0, fin2 = 1'b0, oe = 1'b1;
  logic       out, pin;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lut3_cell u_lut3_cell (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .in0_sel_i(s0), .in1_sel_i(s1), .in2_sel_i(s2),
    .evt_i(evt), .tmr_i(tmr), .truth_i(tt),
    .filt_sync_i(fsync), .fclk_in2_i(fin2), .oe_i(oe),
    .out_o(out), .pin_o(pin)
  );

  // {s2, s1, s0, evt, tmr, truth, expected}
  localparam logic [20:0] VECS [9] = '{
    {2'd2, 2'd2, 2'd2, 3'b101, 3'b000, 8'h20, 1'b1},
    {2'd2, 2'd2, 2'd2, 3'b101, 3'b000, 8'hDF, 1'b0},
    {2'd3, 2'd3, 2'd3, 3'b000, 3'b011, 8'h08, 1'b1},
    {2'd0, 2'd0, 2'd0, 3'b111, 3'b111, 8'h01, 1'b1},
    {2'd0, 2'd0, 2'd0, 3'b111, 3'b111, 8'hFE, 1'b0},
    {2'd0, 2'd3, 2'd2, 3'b001, 3'b010, 8'h08, 1'b1},
    {2'd2, 2'd2, 2'd3, 3'b100, 3'b001, 8'h40, 1'b0},
    {2'd3, 2'd2, 2'd2, 3'b011, 3'b000, 8'h88, 1'b1},
    {2'd0, 2'd0, 2'd2, 3'b110, 3'b000, 8'h02, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic prev;
    int rises;
    // R1: reset with chain selected and an all-one table
    en = 1; fsync = 1; tt = 8'hFF;
    step(3);
    check("R1 reset out", out, 1'b0);
    check("R1 reset pin", pin, 1'b0);
    rst_n = 1;
    en = 0; fsync = 0;
    #1;
    check("R1 disabled out", out, 1'b0);
    check("R1 disabled pin", pin, 1'b0);
    step(1);

    // R2 R3 R4: direct path vectors
    en = 1; oe = 1; fsync = 0;
    foreach (VECS[i]) begin
      {s2, s1, s0, evt, tmr, tt} = VECS[i][20:1];
      #1;
      check($sformatf("R2/R3/R4 vec%0d out", i), out, VECS[i][0]);
      check($sformatf("R3 vec%0d pin", i), pin, VECS[i][0]);
      step(1);
    end

    // R9: pin gated
    {s2, s1, s0} = 6'd0; tt = 8'hFF; oe = 0;
    #1;
    check("R9 out with oe low", out, 1'b1);
    check("R9 pin with oe low", pin, 1'b0);
    oe = 1;
    #1;
    check("R9 pin with oe high", pin, 1'b1);

    // R7: direct path, inverted feedback toggles each clock
    s0 = 2'd1; tt = 8'h01;
    step(1);
    prev = out;
    step(1);
    check("R7 toggle 1", out, ~prev);
    prev = out;
    step(1);
    check("R7 toggle 2", out, ~prev);

    // R10: disable clears chain
    en = 0; step(1);
    check("R10 out while disabled", out, 1'b0);
    en = 1; fsync = 1; fin2 = 0; s0 = 2'd0; tt = 8'hFF;
    step(1);
    check("R10 first edge after enable", out, 1'b0);
    step(1);
    check("R10 second edge", out, 1'b1);

    // R5: two-edge latency on system clock
    en = 0; step(1); en = 1;
    s0 = 2'd2; s1 = 2'd0; s2 = 2'd0; evt = 3'b000; tt = 8'h02;
    step(2);
    evt[0] = 1'b1;
    step(1);
    check("R5 after one edge", out, 1'b0);
    step(1);
    check("R5 after two edges", out, 1'b1);

    // R6: stepped by slot 2 rising edges
    en = 0; step(1); en = 1;
    fin2 = 1; s0 = 2'd3; s1 = 2'd0; s2 = 2'd2; tmr = 3'b001; evt = 3'b000; tt = 8'h20;
    step(2);
    evt[2] = 1'b1; step(1);
    step(4);
    check("R6 hold while slot2 high", out, 1'b0);
    evt[2] = 1'b0; step(1);
    evt[2] = 1'b1; step(1);
    check("R6 second rising edge", out, 1'b1);
    tmr[0] = 1'b0; step(3);
    check("R6 hold with slot0 changed", out, 1'b1);

    // R8: divide by four
    en = 0; step(1); en = 1;
    s0 = 2'd1; s1 = 2'd3; s2 = 2'd2; tmr = 3'b000; evt = 3'b000; tt = 8'h10;
    fsync = 1; fin2 = 1;
    step(2);
    rises = 0; prev = out;
    for (int n = 1; n <= 8; n++) begin
      evt[2] = 1'b1; step(1);
      evt[2] = 1'b0; step(3);
      check($sformatf("R8 after pulse %0d", n), out, (n % 4 == 2) || (n % 4 == 3));
      if (out && !prev) rises++;
      prev = out;
    end
    check("R8 two rises in eight pulses", rises == 2, 1'b1);

    finish_run();
  end
endmodule